// File: doc/BRIEF.md
# Extended Match-Timer Bank

This block is a bank of eight match channels, indexed 0 to 7 inside the block. Their interrupt status and enable bits sit at positions 4 to 11 of a twelve-bit status/enable space, because four base channels elsewhere own positions 0 to 3. Each channel owns a counter, a match value and a control word. The control word picks one of eight rate strobes that advance the counter. It also says whether the match compares against the channel's own counter or against a master counter borrowed from a neighbour. A match can clear the counter, and the channel can re-arm itself after every match or fire only once. All channels raise one combined interrupt line.

Software reaches the bank through a single-cycle word register port whose read data is registered. On two channels, reading the counter can also freeze the counter of the channel below into a snapshot register. This gives a coherent pair of counter values from two reads. The rate strobes come from outside, one bit per source.

Top module: `xtmr_bank`

## Requirements
- R1: After reset every control, counter, match, status, enable and snapshot register reads zero, `irq` is low, and no counter advances until a control write gives it a clock source.
- R2: A running counter advances by exactly one, with wrap at DATA_W bits, on each clock cycle in which the rate strobe selected by control bits [2:0] is high; a source whose SRC_PRESENT bit is 0 (sources 6 and 7 by default) never advances it. Source 5 carries the externally supplied clock.
- R3: A control write updates the clock selection only when control bit 7 is set or the channel is a master (index 0, 4 or 6); otherwise the previous selection, including "stopped", is kept.
- R4: Control writes keep bits [7:0] on indices 0–3 and bits [9:0] on indices 4–7; on indices 4–7, bit 8 set forces clock source 0.
- R5: A write to a counter register (word address 0x08 + index) loads it in that cycle; counting resumes on the next selected strobe, and a read returns the value.
- R6: With control bit 7 clear, a channel compares against the counter of its master: index 0 for indices 0–3, index 4 for indices 4–5, index 6 for indices 6–7.
- R7: A channel matches when its compared counter steps onto its match value (word address 0x00 + index); the match sets status bit 4+index only if enable bit 4+index is 1.
- R8: With control bits 3 and 7 both set, a match loads the channel's own counter with zero instead of the match value.
- R9: With control bit 6 clear a channel matches at most once, until its match or counter register is written; with bit 6 set it matches on every pass.
- R10: Writing 1 to status bit 4+index (address 0x18) clears it, a new match in the same cycle wins, and `irq` is high exactly while any status bit 4–11 is set.
- R11: Reading the counter of index 5 or 7 while its control bit 9 is set copies the counter of index 4 or 6 into the snapshot register (address 0x1A), which holds until the next capture.
- R12: `rdata` is updated in the cycle after `rd_en`; control at 0x10 + index, status at 0x18, enable at 0x19 with bits 4–11 used, unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_tick | input | 8 | Rate strobes, one per clock source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Combined interrupt of all eight channels |

## Verification
The bench builds the bank with DATA_W = 12 and the default SRC_PRESENT of 8'h3F. The narrow counter brings wrap-around, and matches found by random match values, within a few thousand cycles. With the default mask, a selection of sources 6 or 7 shows the stopped case while their strobes still toggle. A behavioural model of all eight channels checks read data and the interrupt every cycle. Scripted phases cover counter borrowing, clear-on-match, one-shot versus periodic operation and snapshot capture.

// File: rtl/xtmr_pkg.sv
package xtmr_pkg;
  localparam int NCH  = 8;
  localparam int NSRC = 8;
  localparam int SELW = $clog2(NSRC);
  localparam int CTLW = 10;
  localparam int STLO = 4;

  // control field positions
  localparam int B_RST   = 3;
  localparam int B_PER   = 6;
  localparam int B_OWN   = 7;
  localparam int B_FORCE = 8;
  localparam int B_SNAP  = 9;

  // word addresses
  localparam logic [4:0] A_MATCH = 5'h00;
  localparam logic [4:0] A_CNT   = 5'h08;
  localparam logic [4:0] A_CTRL  = 5'h10;
  localparam logic [4:0] A_STAT  = 5'h18;
  localparam logic [4:0] A_EN    = 5'h19;
  localparam logic [4:0] A_SNAP  = 5'h1A;

  // channel whose counter a borrowing channel compares against
  function automatic int master_of(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction

  function automatic bit is_master(input int idx);
    return master_of(idx) == idx;
  endfunction

  function automatic logic [CTLW-1:0] keep_mask(input int idx);
    return (idx < 4) ? 10'h0FF : 10'h3FF;
  endfunction

  function automatic bit takes_sel(input int idx, input logic [CTLW-1:0] c);
    return c[B_OWN] || is_master(idx);
  endfunction

  function automatic logic [SELW-1:0] src_of(input logic [CTLW-1:0] c);
    return c[B_FORCE] ? '0 : c[SELW-1:0];
  endfunction
endpackage

// File: rtl/xtmr_ctrl.sv
module xtmr_ctrl import xtmr_pkg::*; #(
  parameter int              IDX         = 0,
  parameter logic [NSRC-1:0] SRC_PRESENT = 8'h3F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CTLW-1:0] wdata,
  input  logic [NSRC-1:0] rate_tick,
  output logic [CTLW-1:0] ctrl,
  output logic            tick
);
  logic [CTLW-1:0] ctrl_q;
  logic [SELW-1:0] sel_q;
  logic            run_q;
  logic [CTLW-1:0] ctrl_new;

  assign ctrl_new = wdata & keep_mask(IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      run_q  <= 1'b0;
    end else if (wr) begin
      ctrl_q <= ctrl_new;
      if (takes_sel(IDX, ctrl_new)) begin
        sel_q <= src_of(ctrl_new);
        run_q <= 1'b1;
      end
    end
  end

  assign ctrl = ctrl_q;
  assign tick = run_q && SRC_PRESENT[sel_q] && rate_tick[sel_q];
endmodule

// File: rtl/xtmr_chan.sv
module xtmr_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_own,
  input  logic [DATA_W-1:0] cmp_cnt_ext,
  input  logic              cmp_tick_ext,
  input  logic              own_sel,
  input  logic              rst_on_match,
  input  logic              periodic,
  input  logic              cnt_wr,
  input  logic              match_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] match,
  output logic              hit
);
  function automatic logic [DATA_W-1:0] next_val(input logic [DATA_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic [DATA_W-1:0] cnt_q, match_q, cmp_cnt;
  logic              armed_q, cmp_tick, clr_own;

  assign cmp_cnt  = own_sel ? cnt_q : cmp_cnt_ext;
  assign cmp_tick = own_sel ? tick_own : cmp_tick_ext;
  assign hit      = armed_q && cmp_tick && (next_val(cmp_cnt) == match_q);
  assign clr_own  = hit && own_sel && rst_on_match;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_wr)   cnt_q <= wdata;
    else if (clr_own)  cnt_q <= '0;
    else if (tick_own) cnt_q <= next_val(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        match_q <= '0;
    else if (match_wr) match_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    armed_q <= 1'b1;
    else if (cnt_wr || match_wr)   armed_q <= 1'b1;
    else if (hit && !periodic)     armed_q <= 1'b0;
  end

  assign cnt   = cnt_q;
  assign match = match_q;

  // R2: a selected strobe steps the counter by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_own && !cnt_wr && !clr_own) |=> cnt_q == next_val($past(cnt_q)));

  // R8: clear-on-match leaves a zero counter
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_own && !cnt_wr) |=> cnt_q == '0);

  // R9: a one-shot channel cannot match in the following cycle
  a_r9_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !periodic && !cnt_wr && !match_wr) |=> !hit);
endmodule

// File: rtl/xtmr_bank.sv
module xtmr_bank import xtmr_pkg::*; #(
  parameter int              DATA_W      = 32,
  parameter logic [NSRC-1:0] SRC_PRESENT = 8'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   rate_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int STW = STLO + NCH;

  logic [DATA_W-1:0] cnt_a   [NCH];
  logic [DATA_W-1:0] match_a [NCH];
  logic [CTLW-1:0]   ctrl_a  [NCH];
  logic [NCH-1:0]    tick_v, hit_v, set_vec, clr_vec;
  logic [NCH-1:0]    status_q, en_q;
  logic [DATA_W-1:0] snap_q, rdata_q, rd_nxt;
  logic [2:0]        idx;
  logic              snap_cap;

  assign idx = addr[2:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int M = master_of(g);

    xtmr_ctrl #(.IDX(g), .SRC_PRESENT(SRC_PRESENT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_en && addr == (A_CTRL + 5'(g))),
      .wdata     (wdata[CTLW-1:0]),
      .rate_tick (rate_tick),
      .ctrl      (ctrl_a[g]),
      .tick      (tick_v[g])
    );

    xtmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_own     (tick_v[g]),
      .cmp_cnt_ext  (cnt_a[M]),
      .cmp_tick_ext (tick_v[M]),
      .own_sel      (ctrl_a[g][B_OWN]),
      .rst_on_match (ctrl_a[g][B_RST]),
      .periodic     (ctrl_a[g][B_PER]),
      .cnt_wr       (wr_en && addr == (A_CNT + 5'(g))),
      .match_wr     (wr_en && addr == (A_MATCH + 5'(g))),
      .wdata        (wdata),
      .cnt          (cnt_a[g]),
      .match        (match_a[g]),
      .hit          (hit_v[g])
    );
  end

  // status and enable
  assign set_vec = hit_v & en_q;
  assign clr_vec = (wr_en && addr == A_STAT) ? wdata[STLO +: NCH] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (wr_en && addr == A_EN) en_q <= wdata[STLO +: NCH];
    end
  end

  assign irq = |status_q;

  // snapshot: odd upper channel captures the counter just below it
  assign snap_cap = rd_en && addr[4:3] == 2'd1 && idx[2] && idx[0]
                    && ctrl_a[idx][B_SNAP];

  always_ff @(posedge clk) begin
    if (!rst_n)        snap_q <= '0;
    else if (snap_cap) snap_q <= cnt_a[{idx[2:1], 1'b0}];
  end

  // register read
  always_comb begin
    rd_nxt = '0;
    case (addr[4:3])
      2'd0: rd_nxt = match_a[idx];
      2'd1: rd_nxt = cnt_a[idx];
      2'd2: rd_nxt = DATA_W'(ctrl_a[idx]);
      default: begin
        if (addr == A_STAT)      rd_nxt = DATA_W'({status_q, {STLO{1'b0}}});
        else if (addr == A_EN)   rd_nxt = DATA_W'({en_q, {STLO{1'b0}}});
        else if (addr == A_SNAP) rd_nxt = snap_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  assign rdata = rdata_q;

  // R10: a cleared bit with no concurrent set is gone next cycle
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & $past(clr_vec & ~set_vec)) == '0);

  // R7: a status bit only rises from an enabled match
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & ~$past(status_q) & ~$past(set_vec)) == '0);

  // R11: snapshot holds without a capture
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cap |=> $stable(snap_q));

  initial begin
    if (DATA_W < STW) $error("DATA_W too narrow for status space");
  end
endmodule

// File: tb/test_xtmr_bank.sv
module test_xtmr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam logic [7:0] PRES = 8'h3F;

  logic         clk, rst_n, wr_en, rd_en;
  logic [7:0]   rate_tick;
  logic [4:0]   addr;
  logic [W-1:0] wdata, rdata;
  logic         irq;

  xtmr_bank #(.DATA_W(W), .SRC_PRESENT(PRES)) i_xtmr_bank (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int    checks = 0, errors = 0, cyc = 0, rmode = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [W-1:0] m_cnt[8], m_match[8], m_rdata, m_snap;
  logic [9:0]   m_ctrl[8];
  logic [2:0]   m_sel[8];
  bit           m_run[8], m_armed[8], tk[8], ht[8];
  logic [7:0]   m_stat, m_en;

  function automatic int boss(input int n);
    return (n < 4) ? 0 : n - (n % 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) begin
        m_cnt[n] = '0; m_match[n] = '0; m_ctrl[n] = '0; m_sel[n] = '0;
        m_run[n] = 0; m_armed[n] = 1;
      end
      m_rdata = '0; m_snap = '0; m_stat = '0; m_en = '0;
    end else begin
      logic [7:0] setv, clrv;
      for (int n = 0; n < 8; n++)
        tk[n] = m_run[n] && PRES[m_sel[n]] && rate_tick[m_sel[n]];
      for (int n = 0; n < 8; n++) begin
        int s;
        s = m_ctrl[n][7] ? n : boss(n);
        ht[n] = m_armed[n] && tk[s] && (W'(m_cnt[s] + 1) == m_match[n]);
      end
      if (rd_en) begin
        int k;
        k = addr % 8;
        if (addr < 8)        m_rdata = m_match[k];
        else if (addr < 16)  m_rdata = m_cnt[k];
        else if (addr < 24)  m_rdata = W'(m_ctrl[k]);
        else if (addr == 24) m_rdata = W'(m_stat) << 4;
        else if (addr == 25) m_rdata = W'(m_en) << 4;
        else if (addr == 26) m_rdata = m_snap;
        else                 m_rdata = '0;
        if (addr >= 8 && addr < 16 && (k == 5 || k == 7) && m_ctrl[k][9])
          m_snap = m_cnt[k-1];
      end
      setv = '0;
      for (int n = 0; n < 8; n++) begin
        bit wc, wm;
        wc = wr_en && addr == 8 + n;
        wm = wr_en && addr == n;
        if (ht[n] && m_en[n]) setv[n] = 1'b1;
        if (wc)                                           m_cnt[n] = wdata;
        else if (ht[n] && m_ctrl[n][7] && m_ctrl[n][3])   m_cnt[n] = '0;
        else if (tk[n])                                   m_cnt[n] = W'(m_cnt[n] + 1);
        if (wm) m_match[n] = wdata;
        if (wc || wm)                  m_armed[n] = 1;
        else if (ht[n] && !m_ctrl[n][6]) m_armed[n] = 0;
      end
      for (int n = 0; n < 8; n++) begin
        if (wr_en && addr == 16 + n) begin
          m_ctrl[n] = wdata[9:0] & ((n < 4) ? 10'h0FF : 10'h3FF);
          if (m_ctrl[n][7] || boss(n) == n) begin
            m_sel[n] = (n >= 4 && m_ctrl[n][8]) ? 3'd0 : m_ctrl[n][2:0];
            m_run[n] = 1;
          end
        end
      end
      clrv = (wr_en && addr == 24) ? wdata[11:4] : 8'h00;
      m_stat = (m_stat & ~clrv) | setv;
      if (wr_en && addr == 25) m_en = wdata[11:4];
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(cur_req, 32'(rdata), 32'(m_rdata));
      check(cur_req, 32'(irq), 32'(m_stat != 0));
    end
  end

  // rate strobes
  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0: rate_tick <= 8'h00;
      2: rate_tick <= 8'hFF;
      default: rate_tick <= {cyc[0], ~cyc[0], cyc % 7 == 0, cyc % 5 == 0,
                             cyc % 4 == 0, cyc % 3 == 0, cyc[0], 1'b1};
    endcase
  end

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [W-1:0] exp, input string req);
    rd(a);
    check(req, 32'(rdata), 32'(exp));
  endtask

  task automatic set_mode(input int m);
    @(posedge clk); rmode = m;
  endtask

  // all strobes on for n+1 counted cycles
  task automatic burst(input int n);
    set_mode(2); repeat (n) @(posedge clk); set_mode(0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rate_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;

    cur_req = "R1";
    check("R1", 32'(irq), 0);
    rd_chk(5'h10, 0, "R1"); rd_chk(5'h08, 0, "R1");
    rd_chk(5'h18, 0, "R1"); rd_chk(5'h1A, 0, "R1");

    cur_req = "R4";
    wr(5'h10, 12'h3FF); rd_chk(5'h10, 12'h0FF, "R4");
    wr(5'h14, 12'hFFF); rd_chk(5'h14, 12'h3FF, "R4");
    cur_req = "R12";
    rd_chk(5'h1D, 0, "R12");

    cur_req = "R5";
    wr(5'h09, 12'h123); rd_chk(5'h09, 12'h123, "R5");

    cur_req = "R2";
    wr(5'h10, 12'h081); wr(5'h08, 12'h000);
    burst(10); rd_chk(5'h08, 12'd11, "R2");
    wr(5'h10, 12'h086); cur_req = "R3"; wr(5'h11, 12'h002);
    burst(10); rd_chk(5'h08, 12'd11, "R2");
    rd_chk(5'h09, 12'h123, "R3");

    cur_req = "R7";
    wr(5'h14, 12'h000);
    wr(5'h12, 12'h080); wr(5'h13, 12'h080);
    wr(5'h0A, 0); wr(5'h0B, 0); wr(5'h02, 5); wr(5'h03, 5);
    wr(5'h19, 12'h040);
    burst(10);
    rd_chk(5'h18, 12'h040, "R7"); check("R7", 32'(irq), 1);
    cur_req = "R10";
    wr(5'h18, 12'h040); rd_chk(5'h18, 12'h000, "R10"); check("R10", 32'(irq), 0);

    cur_req = "R11";
    wr(5'h14, 12'h080); wr(5'h15, 12'h280); wr(5'h0C, 12'h321);
    rd(5'h0D); rd_chk(5'h1A, 12'h321, "R11");
    wr(5'h0C, 12'h111); rd_chk(5'h1A, 12'h321, "R11");

    cur_req = "R6";
    wr(5'h0C, 0); wr(5'h15, 12'h000); wr(5'h05, 20); wr(5'h19, 12'h200);
    burst(29);
    rd_chk(5'h18, 12'h200, "R6");
    wr(5'h18, 12'hFF0);

    cur_req = "R8";
    wr(5'h16, 12'h0C8); wr(5'h06, 7); wr(5'h0E, 0); wr(5'h19, 12'h400);
    burst(29);
    rd_chk(5'h0E, 12'd2, "R8");
    cur_req = "R9";
    rd_chk(5'h18, 12'h400, "R9");
    wr(5'h18, 12'hFF0); wr(5'h19, 12'h000);

    cur_req = "R9";
    set_mode(1);
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0, 1: wr(5'($urandom % 8), W'($urandom));
        2:    wr(5'(8 + $urandom % 8), W'($urandom));
        3:    wr(5'(16 + $urandom % 8), W'($urandom));
        4:    wr(5'h19, W'($urandom));
        5:    wr(5'h18, W'($urandom));
        default: rd(5'($urandom % 27));
      endcase
      repeat ($urandom % 12) @(negedge clk);
    end
    set_mode(0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule